// File: doc/BRIEF.md
# Periodic Down-Counting Tick Timer

This block is a free-running periodic timer for a processor subsystem. Software loads a period value, clears the live counter and then enables counting. From then on the counter steps down by one on every processor clock. When it reaches zero it reloads the period on the following count cycle. Each arrival at zero latches a sticky wrap flag and, if interrupts are enabled, raises a one-cycle request pulse.

Access is through a small single-cycle register bus with three word registers. Control/status is at offset 0x0, the period value at offset 0x4 and the live count at offset 0x8. Reads are combinational and return the state in the cycle of the access. A debug-halt input freezes the count. The only count source is the processor clock, so the clock-source bit always reads back as one. A period of zero stops the counter once it reaches zero.

Top module: `tick_timer`

## Requirements
- R1: After reset the count, the period and all control bits are zero and the request line is low. A read of offset 0x0 returns 0x0000_0004.
- R2: While enabled (control bit 0 is 1) and not halted, each clock lowers a nonzero count by exactly one.
- R3: While enabled and not halted, a count of zero takes the stored period on the next clock. With a stored period of zero, the count stays at zero.
- R4: The wrap flag (control bit 16) is set on the clock where the count steps from 1 to 0. A read of offset 0x0 returns the flag and clears it afterwards. If a step to zero falls in the same cycle as the read, the flag ends up set.
- R5: A write of any data to offset 0x8 makes the count zero and clears the wrap flag on the next clock. It raises no request, and it overrides a count step in the same cycle.
- R6: The request line is high for exactly the one cycle after a 1-to-0 step, and only if the interrupt-enable bit (control bit 1) is set.
- R7: While the halt input is high, the count, the wrap flag and the request line keep their values or stay low. A write to offset 0x8 still takes effect.
- R8: A read of offset 0x0 returns enable in bit 0 and interrupt-enable in bit 1. Bit 2 is always 1, bit 16 holds the flag and all other bits are 0. Writes to offset 0x0 change only bits 0 and 1. The period register at offset 0x4 stores and returns the low 24 bits of a write. Any unmapped offset reads 0.
- R9: A read of offset 0x8 returns the count as it stands in the cycle of the access.
- R10: While enable is 0, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock, the count source |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| dbg_halt | input | 1 | Freezes counting while high |
| tick_irq | output | 1 | One-cycle tick request |

## Verification
The assertions assume that a bus access lasts exactly one cycle and that only one register is addressed at a time. Write and read are mutually exclusive by construction of the single `bus_wr` line. The halt input is assumed to change only between clock edges. The bench drives every input at the falling edge, one access per call, so a flag clear by a read can never land on a write to the count. Period values are drawn mostly from a small range, so that wraps, zero periods and periods of one occur often.

// File: rtl/tick_pkg.sv
package tick_pkg;
   typedef enum logic [1:0] {
      SEL_NONE,
      SEL_CTRL,
      SEL_PERIOD,
      SEL_COUNT
   } tick_sel_e;

   localparam int OFS_CTRL   = 0;
   localparam int OFS_PERIOD = 4;
   localparam int OFS_COUNT  = 8;

   localparam int BIT_RUN = 0;
   localparam int BIT_IE  = 1;
   localparam int BIT_SRC = 2;
endpackage

// File: rtl/tick_decode.sv
module tick_decode
   import tick_pkg::*;
#(
   parameter int ADDR_W = 4
) (
   input  logic              sel,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   output tick_sel_e         which,
   output logic              wr_ctrl,
   output logic              wr_period,
   output logic              wr_count,
   output logic              rd_ctrl
);
   always_comb begin
      which = SEL_NONE;
      if (addr == ADDR_W'(OFS_CTRL))        which = SEL_CTRL;
      else if (addr == ADDR_W'(OFS_PERIOD)) which = SEL_PERIOD;
      else if (addr == ADDR_W'(OFS_COUNT))  which = SEL_COUNT;
   end

   assign wr_ctrl   = sel &&  wr && (which == SEL_CTRL);
   assign wr_period = sel &&  wr && (which == SEL_PERIOD);
   assign wr_count  = sel &&  wr && (which == SEL_COUNT);
   assign rd_ctrl   = sel && !wr && (which == SEL_CTRL);
endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             clr,
   input  logic [CNT_W-1:0] period,
   output logic [CNT_W-1:0] count,
   output logic             hit
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic at_zero;
   assign at_zero = (count == '0);
   assign hit     = run && !clr && (count == ONE);

   always_ff @(posedge clk) begin
      if (!rst_n)       count <= '0;
      else if (clr)     count <= '0;
      else if (run) begin
         if (at_zero)   count <= period;
         else           count <= count - ONE;
      end
   end
endmodule

// File: rtl/tick_status.sv
module tick_status (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_ctrl,
   input  logic wd_run,
   input  logic wd_ie,
   input  logic rd_ctrl,
   input  logic clr,
   input  logic hit,
   output logic run_en,
   output logic irq_en,
   output logic flag,
   output logic irq
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_en <= 1'b0;
         irq_en <= 1'b0;
      end else if (wr_ctrl) begin
         run_en <= wd_run;
         irq_en <= wd_ie;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       flag <= 1'b0;
      else if (clr)     flag <= 1'b0;
      else if (hit)     flag <= 1'b1;
      else if (rd_ctrl) flag <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= hit && irq_en;
   end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
   import tick_pkg::*;
#(
   parameter int ADDR_W   = 4,
   parameter int DATA_W   = 32,
   parameter int CNT_W    = 24,
   parameter int FLAG_BIT = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              dbg_halt,
   output logic              tick_irq
);
   generate
      if (CNT_W > DATA_W)             begin : g_bad_cnt  $error("CNT_W exceeds DATA_W"); end
      if (FLAG_BIT >= DATA_W)         begin : g_bad_flag $error("FLAG_BIT outside word"); end
      if (FLAG_BIT <= BIT_SRC)        begin : g_bad_pos  $error("FLAG_BIT overlaps control bits"); end
      if ((1 << ADDR_W) <= OFS_COUNT) begin : g_bad_addr $error("ADDR_W too narrow"); end
   endgenerate

   tick_sel_e        which;
   logic             wr_ctrl, wr_period, wr_count, rd_ctrl;
   logic             run_en, irq_en, flag_q, hit;
   logic [CNT_W-1:0] period_q, cur_q;
   logic [DATA_W-1:0] ctrl_word;
   logic             unused_wdata;

   assign unused_wdata = &{1'b0, bus_wdata};

   tick_decode #(.ADDR_W(ADDR_W)) u_decode (
      .sel(bus_sel), .wr(bus_wr), .addr(bus_addr), .which(which),
      .wr_ctrl(wr_ctrl), .wr_period(wr_period), .wr_count(wr_count),
      .rd_ctrl(rd_ctrl)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)         period_q <= '0;
      else if (wr_period) period_q <= bus_wdata[CNT_W-1:0];
   end

   tick_counter #(.CNT_W(CNT_W)) u_counter (
      .clk(clk), .rst_n(rst_n), .run(run_en && !dbg_halt), .clr(wr_count),
      .period(period_q), .count(cur_q), .hit(hit)
   );

   tick_status u_status (
      .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl),
      .wd_run(bus_wdata[BIT_RUN]), .wd_ie(bus_wdata[BIT_IE]),
      .rd_ctrl(rd_ctrl), .clr(wr_count), .hit(hit),
      .run_en(run_en), .irq_en(irq_en), .flag(flag_q), .irq(tick_irq)
   );

   generate
      for (genvar b = 0; b < DATA_W; b++) begin : g_ctrl
         if (b == BIT_RUN)       begin : g_run  assign ctrl_word[b] = run_en; end
         else if (b == BIT_IE)   begin : g_ie   assign ctrl_word[b] = irq_en; end
         else if (b == BIT_SRC)  begin : g_src  assign ctrl_word[b] = 1'b1;   end
         else if (b == FLAG_BIT) begin : g_flag assign ctrl_word[b] = flag_q; end
         else                    begin : g_zero assign ctrl_word[b] = 1'b0;   end
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      if (bus_sel && !bus_wr) begin
         case (which)
            SEL_CTRL:   bus_rdata = ctrl_word;
            SEL_PERIOD: bus_rdata = DATA_W'(period_q);
            SEL_COUNT:  bus_rdata = DATA_W'(cur_q);
            default:    bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
   parameter int ADDR_W   = 4,
   parameter int DATA_W   = 32,
   parameter int CNT_W    = 24,
   parameter int FLAG_BIT = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              dbg_halt,
   input logic              tick_irq,
   input logic [CNT_W-1:0]  cur,
   input logic [CNT_W-1:0]  period,
   input logic              flag,
   input logic              run_en
);
   logic wr_cur, rd_ctl, stepping;
   assign wr_cur   = bus_sel &&  bus_wr && (bus_addr == ADDR_W'(8));
   assign rd_ctl   = bus_sel && !bus_wr && (bus_addr == ADDR_W'(0));
   assign stepping = run_en && !dbg_halt && !wr_cur;

   AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      stepping && (cur != '0) |=> cur == $past(cur) - CNT_W'(1)); // R2
   AST_WRAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      stepping && (cur == '0) |=> cur == $past(period)); // R3
   AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      stepping && (cur == CNT_W'(1)) |=> flag); // R4
   AST_CUR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cur |=> (cur == '0) && !flag && !tick_irq); // R5
   AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      tick_irq |=> !tick_irq); // R6
   AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      tick_irq |-> (cur == '0) && ($past(cur) == CNT_W'(1))); // R6
   AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_halt && !wr_cur |=> $stable(cur) && !tick_irq); // R7
   AST_SRC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ctl |-> bus_rdata[2]); // R8
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en && !wr_cur |=> $stable(cur)); // R10
endmodule

bind tick_timer tick_timer_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .FLAG_BIT(FLAG_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
   .bus_addr(bus_addr), .bus_rdata(bus_rdata), .dbg_halt(dbg_halt),
   .tick_irq(tick_irq), .cur(cur_q), .period(period_q), .flag(flag_q),
   .run_en(run_en)
);

// File: tb/tick_timer_bench.sv
module tick_timer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0, dbg_halt = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        tick_irq;

   int checks = 0, fails = 0;
   bit done = 0;

   logic [23:0] m_cur = '0, m_per = '0;
   logic        m_run = 0, m_ie = 0, m_flag = 0, m_irq = 0;

   always #10 clk = ~clk;

   tick_timer u_tick_timer (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .dbg_halt(dbg_halt), .tick_irq(tick_irq)
   );

   function automatic logic [31:0] exp_read(input logic [3:0] a);
      case (a)
         4'h0:    return {15'b0, m_flag, 13'b0, 1'b1, m_ie, m_run};
         4'h4:    return {8'b0, m_per};
         4'h8:    return {8'b0, m_cur};
         default: return 32'h0;
      endcase
   endfunction

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic model_step(input logic s, input logic w, input logic [3:0] a,
                             input logic [31:0] d, input logic h);
      logic wc, rc, go, hit;
      wc  = s && w && (a == 4'h8);
      rc  = s && !w && (a == 4'h0);
      go  = m_run && !h;
      hit = go && !wc && (m_cur == 24'd1);
      m_irq = hit && m_ie;
      if (wc)        m_flag = 0;
      else if (hit)  m_flag = 1;
      else if (rc)   m_flag = 0;
      if (wc)        m_cur = '0;
      else if (go)   m_cur = (m_cur != 0) ? m_cur - 24'd1 : m_per;
      if (s && w && a == 4'h0) begin m_run = d[0]; m_ie = d[1]; end
      if (s && w && a == 4'h4) m_per = d[23:0];
   endtask

   task automatic cyc(input logic s, input logic w, input logic [3:0] a,
                      input logic [31:0] d, input logic h, input string tag);
      bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d; dbg_halt = h;
      #1;
      if (s && !w) check(tag, bus_rdata, exp_read(a));
      @(posedge clk);
      model_step(s, w, a, d, h);
      @(negedge clk);
      check("R6 irq", {31'b0, tick_irq}, {31'b0, m_irq});
      bus_sel = 0; bus_wr = 0;
   endtask

   task automatic rd(input logic [3:0] a, input string tag);
      cyc(1, 0, a, 32'h0, 0, tag);
   endtask
   task automatic wrt(input logic [3:0] a, input logic [31:0] d);
      cyc(1, 1, a, d, 0, "write");
   endtask
   task automatic idle_until_one(input string tag);
      for (int i = 0; i < 64 && m_cur != 24'd1; i++) cyc(0, 0, 4'h0, 0, 0, tag);
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      check("R1 irq", {31'b0, tick_irq}, 32'h0);
      rd(4'h0, "R1 ctrl");
      rd(4'h4, "R1 period");
      rd(4'h8, "R1 count");
      // R2 / R3 setup and wrap with period 3
      wrt(4'h4, 32'd3);
      wrt(4'h8, 32'hDEAD_BEEF);
      wrt(4'h0, 32'h3);
      for (int i = 0; i < 10; i++) rd(4'h8, (i % 4 == 0) ? "R3 wrap" : "R2 step");
      rd(4'h0, "R4 flag read");
      rd(4'h0, "R4 flag cleared");
      // R4 set wins over same-cycle clear
      idle_until_one("R4 wait");
      rd(4'h0, "R4 read at step");
      rd(4'h0, "R4 flag kept");
      // R5 write to count in the step cycle
      idle_until_one("R5 wait");
      wrt(4'h8, 32'h1234_5678);
      rd(4'h8, "R5 count zero");
      rd(4'h0, "R5 flag clear");
      // R7 halt
      for (int i = 0; i < 6; i++) cyc(1, 0, 4'h8, 0, 1, "R7 halt");
      idle_until_one("R7 wait");
      cyc(1, 0, 4'h8, 0, 1, "R7 halt at one");
      cyc(1, 0, 4'h0, 0, 1, "R7 no flag");
      // R3 zero period stops
      wrt(4'h4, 32'h0);
      for (int i = 0; i < 8; i++) rd(4'h8, "R3 zero period");
      // R10 disabled holds
      wrt(4'h4, 32'd9);
      wrt(4'h0, 32'h1);
      rd(4'h8, "R3 reload");
      wrt(4'h0, 32'h0);
      for (int i = 0; i < 5; i++) rd(4'h8, "R10 hold");
      // R8 register fields
      wrt(4'h0, 32'hFFFF_FFFF);
      rd(4'h0, "R8 ctrl bits");
      wrt(4'h4, 32'hFFFF_FFFF);
      rd(4'h4, "R8 period width");
      rd(4'hC, "R8 unmapped");
      rd(4'h2, "R8 unmapped");
      wrt(4'h0, 32'h0000_0004);
      rd(4'h0, "R8 ctrl off");
      wrt(4'h4, 32'd2);
      wrt(4'h8, 32'h0);
      wrt(4'h0, 32'h3);
      // random phase
      for (int i = 0; i < 4000; i++) begin
         int r;
         logic h;
         r = $urandom_range(0, 99);
         h = ($urandom_range(0, 9) < 2);
         if (r < 55)      cyc(0, 0, 4'h0, 0, h, "R2 idle");
         else if (r < 70) cyc(1, 0, 4'h8, 0, h, "R9 count read");
         else if (r < 80) cyc(1, 0, 4'h0, 0, h, "R4 ctrl read");
         else if (r < 84) cyc(1, 0, 4'(4 * $urandom_range(0, 3)), 0, h, "R8 read");
         else if (r < 90) cyc(1, 1, 4'h4,
                              ($urandom_range(0, 9) == 0) ? $urandom() : 32'($urandom_range(0, 6)),
                              h, "R3 period");
         else if (r < 95) cyc(1, 1, 4'h0, ($urandom_range(0, 7) == 0) ? 32'h2 : 32'h3 | ($urandom() & 32'hFFFF_FFFC), h, "R10 ctrl");
         else             cyc(1, 1, 4'h8, $urandom(), h, "R5 count write");
      end
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule